// File: doc/BRIEF.md
# Direct-Mapped TLB Address Translator

This block turns 32-bit virtual addresses into physical addresses for an instruction fetch port and a data load/store port at the same time. Each port looks up its own single-way, direct-mapped table of 64 entries. Pages are 8 KiB. Each entry is made of a match word, which holds the virtual page tag and a valid flag, and a translate word, which holds the physical page and the access-rights bits. Software loads entries one word at a time through a plain write strobe.

The lookup is combinational. In the same cycle, each port returns the physical address, a hit flag, the rights granted to the current privilege and a two-bit fault class. Translation is skipped when it is disabled. It is also skipped for supervisor accesses to the lowest 8 KiB page. When a faulting request is presented, the block keeps its virtual address in a register at the next clock edge. An exception unit can read that register.

Top module: `tlb_xlate`

## Requirements
- R1: Reset clears every valid flag in both tables and sets `fault_addr` to 0. After reset, every translated lookup reports a miss.
- R2: A lookup hits when the entry selected by virtual address bits [18:13] is valid and its tag (match word bits [31:13]) equals virtual address bits [31:13]. On a hit, the physical address is translate word bits [31:13] followed by virtual address bits [12:0].
- R3: A tag mismatch or a cleared valid flag (match word bit 0) gives hit=0, no rights and fault code 1 (miss) on a requesting port.
- R4: In the data translate word, bit 6 is user read, bit 7 user write, bit 8 supervisor read and bit 9 supervisor write. A hit load without read rights, or a hit store without write rights, for the current privilege gives fault code 2 (page fault).
- R5: In the instruction translate word, bit 6 is supervisor execute and bit 7 is user execute. A hit fetch without execute rights for the current privilege gives fault code 2.
- R6: With `xlate_on` low, both ports return the virtual address unchanged, hit=1, all rights granted and fault code 0.
- R7: In supervisor mode, addresses below 0x2000 bypass translation as in R6. In user mode they are translated.
- R8: An entry write takes effect at the clock edge that samples the strobe. A lookup in that same cycle sees the previous contents.
- R9: At a clock edge where a requesting port shows a nonzero fault, `fault_addr` captures that port's virtual address. The instruction port wins when both ports fault. Otherwise `fault_addr` holds its value.
- R10: A port whose request input is low reports fault code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xlate_on | input | 1 | Translation enable |
| super_mode | input | 1 | 1 = supervisor privilege, 0 = user |
| wr_en | input | 1 | Entry write strobe |
| wr_dtlb | input | 1 | Write target: 0 = instruction table, 1 = data table |
| wr_xlat | input | 1 | Word select: 0 = match word, 1 = translate word |
| wr_idx | input | 6 | Entry index to write |
| wr_val | input | 32 | Word value to write |
| i_req | input | 1 | Fetch request |
| i_vaddr | input | 32 | Fetch virtual address |
| i_paddr | output | 32 | Fetch physical address |
| i_hit | output | 1 | Fetch lookup hit or bypass |
| i_exec | output | 1 | Execute right granted |
| i_fault | output | 2 | 0 none, 1 miss, 2 page fault |
| d_req | input | 1 | Load/store request |
| d_store | input | 1 | 1 = store, 0 = load |
| d_vaddr | input | 32 | Data virtual address |
| d_paddr | output | 32 | Data physical address |
| d_hit | output | 1 | Data lookup hit or bypass |
| d_rd | output | 1 | Read right granted |
| d_wr | output | 1 | Write right granted |
| d_fault | output | 2 | 0 none, 1 miss, 2 page fault |
| fault_addr | output | 32 | Last faulting virtual address |

## Verification
The hardest case to reach from the ports is a lookup that meets a write to the same entry in the same cycle. There, the answer must come from the old contents while the new contents are already on the write bus. The stimulus makes this happen often by writing to and looking up a small pool of eight indices and four tags in the same random cycles. Directed steps also rewrite an entry while it is being looked up. A second case is both ports faulting in one cycle. The random mix hits it often because unwritten entries miss, and a directed step forces it with distinct addresses so the priority of the instruction port is visible.

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int AW = 32,
  parameter int PAGE_BITS = 13,
  parameter int IDX_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xlate_on,
  input  logic              super_mode,
  input  logic              wr_en,
  input  logic              wr_dtlb,
  input  logic              wr_xlat,
  input  logic [IDX_BITS-1:0] wr_idx,
  input  logic [AW-1:0]     wr_val,
  input  logic              i_req,
  input  logic [AW-1:0]     i_vaddr,
  output logic [AW-1:0]     i_paddr,
  output logic              i_hit,
  output logic              i_exec,
  output logic [1:0]        i_fault,
  input  logic              d_req,
  input  logic              d_store,
  input  logic [AW-1:0]     d_vaddr,
  output logic [AW-1:0]     d_paddr,
  output logic              d_hit,
  output logic              d_rd,
  output logic              d_wr,
  output logic [1:0]        d_fault,
  output logic [AW-1:0]     fault_addr
);
  localparam int ENTRIES = 1 << IDX_BITS;
  localparam int VW = AW - PAGE_BITS;
  localparam logic [1:0] F_NONE = 2'd0, F_MISS = 2'd1, F_PAGE = 2'd2;

  logic [VW-1:0] i_tag [ENTRIES];
  logic [VW-1:0] d_tag [ENTRIES];
  logic [VW-1:0] i_ppn [ENTRIES];
  logic [VW-1:0] d_ppn [ENTRIES];
  logic [1:0]    i_rt  [ENTRIES];
  logic [3:0]    d_rt  [ENTRIES];
  logic [ENTRIES-1:0] i_vld, d_vld;

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_val[PAGE_BITS-1:10], wr_val[5:1]};

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (!wr_xlat) begin
        if (wr_dtlb) d_tag[wr_idx] <= wr_val[AW-1:PAGE_BITS];
        else         i_tag[wr_idx] <= wr_val[AW-1:PAGE_BITS];
      end else if (wr_dtlb) begin
        d_ppn[wr_idx] <= wr_val[AW-1:PAGE_BITS];
        d_rt[wr_idx]  <= wr_val[9:6];
      end else begin
        i_ppn[wr_idx] <= wr_val[AW-1:PAGE_BITS];
        i_rt[wr_idx]  <= wr_val[7:6];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_vld <= '0;
      d_vld <= '0;
    end else if (wr_en && !wr_xlat) begin
      if (wr_dtlb) d_vld[wr_idx] <= wr_val[0];
      else         i_vld[wr_idx] <= wr_val[0];
    end
  end

  // instruction port
  logic [VW-1:0] i_vpn;
  logic [IDX_BITS-1:0] i_ix;
  logic i_bypass, i_match;
  assign i_vpn    = i_vaddr[AW-1:PAGE_BITS];
  assign i_ix     = i_vpn[IDX_BITS-1:0];
  assign i_bypass = !xlate_on || (super_mode && i_vpn == '0);
  assign i_match  = i_vld[i_ix] && (i_tag[i_ix] == i_vpn);
  assign i_hit    = i_bypass || i_match;
  assign i_exec   = i_bypass || (i_match && (super_mode ? i_rt[i_ix][0] : i_rt[i_ix][1]));
  assign i_paddr  = i_bypass ? i_vaddr : {i_ppn[i_ix], i_vaddr[PAGE_BITS-1:0]};
  assign i_fault  = !i_req ? F_NONE : !i_hit ? F_MISS : !i_exec ? F_PAGE : F_NONE;

  // data port: rights {sw, sr, uw, ur}
  logic [VW-1:0] d_vpn;
  logic [IDX_BITS-1:0] d_ix;
  logic d_bypass, d_match;
  assign d_vpn    = d_vaddr[AW-1:PAGE_BITS];
  assign d_ix     = d_vpn[IDX_BITS-1:0];
  assign d_bypass = !xlate_on || (super_mode && d_vpn == '0);
  assign d_match  = d_vld[d_ix] && (d_tag[d_ix] == d_vpn);
  assign d_hit    = d_bypass || d_match;
  assign d_rd     = d_bypass || (d_match && (super_mode ? d_rt[d_ix][2] : d_rt[d_ix][0]));
  assign d_wr     = d_bypass || (d_match && (super_mode ? d_rt[d_ix][3] : d_rt[d_ix][1]));
  assign d_paddr  = d_bypass ? d_vaddr : {d_ppn[d_ix], d_vaddr[PAGE_BITS-1:0]};
  assign d_fault  = !d_req ? F_NONE : !d_hit ? F_MISS :
                    (d_store ? !d_wr : !d_rd) ? F_PAGE : F_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       fault_addr <= '0;
    else if (i_fault != F_NONE)       fault_addr <= i_vaddr;
    else if (d_fault != F_NONE)       fault_addr <= d_vaddr;
  end

  // R9
  ifetch_fault_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(i_req) && $past(i_fault) != F_NONE) |-> fault_addr == $past(i_vaddr));
  // R9
  fault_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(i_fault) == F_NONE && $past(d_fault) == F_NONE) |-> $stable(fault_addr));
  // R6
  bypass_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xlate_on |-> (i_fault == F_NONE && d_fault == F_NONE && i_paddr == i_vaddr && d_paddr == d_vaddr));
  // R3
  miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_fault == F_MISS) |-> (!d_hit && !d_rd && !d_wr));
  // R10
  idle_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!i_req |-> i_fault == F_NONE) and (!d_req |-> d_fault == F_NONE));
  // R4
  data_pf_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_fault == F_PAGE) |-> d_hit);
endmodule

// File: tb/sim_tlb_xlate.sv
`timescale 1ns/1ps
module sim_tlb_xlate;
  logic clk = 0, rst_n = 0;
  logic xlate_on = 0, super_mode = 0, wr_en = 0, wr_dtlb = 0, wr_xlat = 0;
  logic [5:0] wr_idx = 0;
  logic [31:0] wr_val = 0, i_vaddr = 0, d_vaddr = 0;
  logic i_req = 0, d_req = 0, d_store = 0;
  logic [31:0] i_paddr, d_paddr, fault_addr;
  logic i_hit, i_exec, d_hit, d_rd, d_wr;
  logic [1:0] i_fault, d_fault;

  always #4 clk = ~clk;

  tlb_xlate u0 (.clk(clk), .rst_n(rst_n), .xlate_on(xlate_on), .super_mode(super_mode),
    .wr_en(wr_en), .wr_dtlb(wr_dtlb), .wr_xlat(wr_xlat), .wr_idx(wr_idx), .wr_val(wr_val),
    .i_req(i_req), .i_vaddr(i_vaddr), .i_paddr(i_paddr), .i_hit(i_hit), .i_exec(i_exec),
    .i_fault(i_fault), .d_req(d_req), .d_store(d_store), .d_vaddr(d_vaddr), .d_paddr(d_paddr),
    .d_hit(d_hit), .d_rd(d_rd), .d_wr(d_wr), .d_fault(d_fault), .fault_addr(fault_addr));

  int checks = 0, errors = 0;
  logic [18:0] m_itag [64], m_dtag [64], m_ippn [64], m_dppn [64];
  logic [63:0] m_iv = '0, m_dv = '0;
  logic [1:0] m_irt [64];
  logic [3:0] m_drt [64];
  logic [31:0] m_fa = 0;
  logic [1:0] e_if, e_df;

  task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic verify(string r);
    logic ibp, dbp, im, dm, ix, rd, wr;
    logic [5:0] ii, di;
    logic [1:0] irt; logic [3:0] drt;
    ii = i_vaddr[18:13]; di = d_vaddr[18:13];
    irt = m_irt[ii]; drt = m_drt[di];
    ibp = !xlate_on || (super_mode && i_vaddr < 32'h2000);
    dbp = !xlate_on || (super_mode && d_vaddr < 32'h2000);
    im = m_iv[ii] && m_itag[ii] == i_vaddr[31:13];
    dm = m_dv[di] && m_dtag[di] == d_vaddr[31:13];
    ix = ibp || (im && (super_mode ? irt[0] : irt[1]));
    rd = dbp || (dm && (super_mode ? drt[2] : drt[0]));
    wr = dbp || (dm && (super_mode ? drt[3] : drt[1]));
    e_if = !i_req ? 2'd0 : !(ibp || im) ? 2'd1 : !ix ? 2'd2 : 2'd0;
    e_df = !d_req ? 2'd0 : !(dbp || dm) ? 2'd1 : (d_store ? !wr : !rd) ? 2'd2 : 2'd0;
    chk(r, "i_hit", 32'(i_hit), 32'(ibp || im));
    chk(r, "i_exec", 32'(i_exec), 32'(ix));
    chk(r, "i_fault", 32'(i_fault), 32'(e_if));
    chk(r, "d_hit", 32'(d_hit), 32'(dbp || dm));
    chk(r, "d_rd", 32'(d_rd), 32'(rd));
    chk(r, "d_wr", 32'(d_wr), 32'(wr));
    chk(r, "d_fault", 32'(d_fault), 32'(e_df));
    if (ibp) chk(r, "i_paddr", i_paddr, i_vaddr);
    else if (im) chk(r, "i_paddr", i_paddr, {m_ippn[ii], i_vaddr[12:0]});
    if (dbp) chk(r, "d_paddr", d_paddr, d_vaddr);
    else if (dm) chk(r, "d_paddr", d_paddr, {m_dppn[di], d_vaddr[12:0]});
    chk(r, "fault_addr", fault_addr, m_fa);
  endtask

  task automatic step(string r);
    #3 verify(r);
    @(posedge clk);
    if (e_if != 0) m_fa = i_vaddr;
    else if (e_df != 0) m_fa = d_vaddr;
    if (wr_en) begin
      if (!wr_xlat) begin
        if (wr_dtlb) begin m_dtag[wr_idx] = wr_val[31:13]; m_dv[wr_idx] = wr_val[0]; end
        else begin m_itag[wr_idx] = wr_val[31:13]; m_iv[wr_idx] = wr_val[0]; end
      end else if (wr_dtlb) begin m_dppn[wr_idx] = wr_val[31:13]; m_drt[wr_idx] = wr_val[9:6]; end
      else begin m_ippn[wr_idx] = wr_val[31:13]; m_irt[wr_idx] = wr_val[7:6]; end
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wr(logic dt, logic xl, logic [5:0] ix, logic [31:0] v);
    wr_en = 1; wr_dtlb = dt; wr_xlat = xl; wr_idx = ix; wr_val = v;
  endtask

  function automatic logic [31:0] pick_va();
    logic [18:0] vpn;
    vpn = 19'(($urandom % 4) << 6) | 19'($urandom % 8);
    return {vpn, 13'($urandom)};
  endfunction

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_7a11));
    for (int k = 0; k < 64; k++) begin
      m_itag[k] = 0; m_dtag[k] = 0; m_ippn[k] = 0; m_dppn[k] = 0; m_irt[k] = 0; m_drt[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: after reset every translated lookup misses, fault_addr 0
    xlate_on = 1; super_mode = 0; i_req = 1; d_req = 1;
    i_vaddr = 32'h0004_6123; d_vaddr = 32'h1234_5678;
    step("R1");
    chk("R1", "fault_addr after miss", fault_addr, 32'h0004_6123);
    // R8: write match word, lookup same cycle sees old (miss)
    i_req = 0; d_req = 1; d_store = 0; d_vaddr = 32'h0000_A010;
    wr(1, 1, 5, 32'h7777_E000 | (32'h1 << 6) | (32'h1 << 8));
    step("R8");
    wr(1, 0, 5, 32'h0000_A001);
    step("R8");
    // now valid: R2 hit, R4 user read granted
    step("R2");
    chk("R2", "d_paddr", d_paddr, 32'h7777_E010);
    // R4: store without user write
    d_store = 1; step("R4");
    // R3: valid cleared while looked up; same cycle still hits (R8), then misses
    d_store = 0; wr(1, 0, 5, 32'h0000_A000); step("R8");
    step("R3");
    // R5: instruction entry with supervisor execute only
    wr(0, 1, 9, 32'h0ABC_0000 | (32'h1 << 6)); step("R5");
    wr(0, 0, 9, 32'h0001_2001); step("R5");
    d_req = 0; i_req = 1; i_vaddr = 32'h0001_2FF0; super_mode = 0; step("R5");
    super_mode = 1; step("R5");
    chk("R5", "i_paddr", i_paddr, 32'h0ABC_0FF0);
    // R7: supervisor low page bypass, user low page translated (miss)
    i_vaddr = 32'h0000_1FFC; d_req = 1; d_vaddr = 32'h0000_0040; d_store = 1; step("R7");
    super_mode = 0; step("R7");
    // R9: both faulting, instruction wins
    i_vaddr = 32'h0000_1ABC; d_vaddr = 32'h0000_0044; step("R9");
    chk("R9", "ifetch priority", fault_addr, 32'h0000_1ABC);
    // R10: requests low, no fault, fault_addr holds
    i_req = 0; d_req = 0; step("R10");
    // R6: translation off
    xlate_on = 0; i_req = 1; d_req = 1; i_vaddr = 32'hDEAD_BEEF; d_vaddr = 32'hCAFE_F00D;
    step("R6");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      xlate_on = ($urandom % 8) != 0;
      super_mode = $urandom;
      i_req = $urandom; d_req = $urandom; d_store = $urandom;
      i_vaddr = pick_va(); d_vaddr = pick_va();
      if ($urandom % 2) begin
        logic [31:0] v;
        v = $urandom;
        if (($urandom % 4) != 0) v[31:13] = 19'(($urandom % 4) << 6);
        wr($urandom, $urandom, 6'($urandom % 8), v);
        if (!wr_xlat) wr_val[18:13] = wr_idx;
      end
      step(n % 2 ? "R2" : "R4");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule